// File: doc/BRIEF.md
# Multi-Processor Boot Load Sequencer

This controller brings up a group of slave processors that share one dual-port program memory. Because that memory has room for a single boot image, which always starts at its base, the processors have to be brought up one after another. After a start pulse the sequencer first puts every processor into reset, issuing one register write per processor. It then works through the processors in ascending index order. For each processor it asks the host for an image and waits for the host to confirm that the image has been placed. It then releases that processor alone, so the processor boots itself from the memory base. Finally it polls the processor's status word until the processor reports that it is ready.

Each processor has its own boot control register, reached through a simple one-cycle write master. The processor's status word is read through a combinational status port that is selected by the current index. A programmable limit bounds each poll. When the limit runs out the sequencer stops, raises an error and reports which processor failed. When the whole sequence succeeds it gives a one-cycle done pulse.

Top module: `boot_sequencer`

## Requirements
- R1: While reset is active and after it is released, `wr_en`, `img_req`, `busy`, `done` and `err` are all 0.
- R2: A start pulse in the idle state is followed by four consecutive one-cycle writes of 00000010h (hold in reset, boot from shared memory). They go to addresses 10800h, 10804h, 10808h and 1080Ch in that order, and no other write comes before them.
- R3: After the halts, `img_req` is 1 and `cur_idx` names the processor that is waiting for its image. No boot control write is issued while `img_req` is 1.
- R4: When `image_ready` is sampled high while `img_req` is 1, the next cycle carries exactly one write of 00000030h, to the address of processor `cur_idx` only (10800h + 4*index).
- R5: Processors are released in ascending index order 0, 1, 2, 3. Processor i+1 is offered an image only after processor i has reported ready.
- R6: During polling, `st_rd` is 1 and `cur_idx` selects the status word. Processor i is ready when the word equals {8'(i+1), 24'h000000}: its top byte holds the processor ID i+1 and its lower three bytes are zero.
- R7: A ready word is accepted only if the status word has been seen holding a different value at some earlier poll cycle after the release. A stale ready word that never changes is never accepted.
- R8: Poll cycles are counted from 0. If the count reaches `tmo_limit` in a cycle without an accepted ready word, `err` rises and `err_idx` holds the failing index. No further writes follow, and both outputs stay unchanged until the next start.
- R9: `done` is 1 for exactly one cycle, right after the last processor's ready word is accepted, and `busy` is 0 in the following cycle.
- R10: A start while `busy` is 1 has no effect. A start while idle or in error begins a fresh sequence from the halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a boot sequence |
| tmo_limit | input | TW | Poll limit per processor, in cycles |
| wr_en | output | 1 | Boot control register write strobe |
| wr_addr | output | AW | Boot control register address |
| wr_data | output | DW | Boot control register write value |
| img_req | output | 1 | Waiting for the host to place an image |
| image_ready | input | 1 | Host confirms the image is in shared memory |
| cur_idx | output | IW | Processor currently handled; selects the status word |
| st_rd | output | 1 | Status word is being polled |
| st_data | input | DW | Status word of processor `cur_idx` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | Poll limit expired |
| err_idx | output | IW | Index of the processor that failed |

## Verification
Two functions can fall in the same poll cycle: a ready word arriving and the poll counter reaching `tmo_limit`. The bench provokes this by setting the limit to exactly the poll cycle in which its processor model presents the ready word, and then one cycle lower. The first run must end in `done` and the second in `err` at index 0. A second collision is a start pulse that arrives while a sequence is under way. The bench judges it by the write log: exactly four halts and four boots, and a single done pulse.

// File: rtl/boot_sequencer.sv
module boot_sequencer #(
  parameter int NPROC = 4,
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int TW = 16,
  parameter int STRIDE = 4,
  parameter logic [AW-1:0] BASE = 20'h10800,
  parameter logic [DW-1:0] HALT_VAL = 32'h0000_0010,
  parameter logic [DW-1:0] BOOT_VAL = 32'h0000_0030,
  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] tmo_limit,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          img_req,
  input  logic          image_ready,
  output logic [IW-1:0] cur_idx,
  output logic          st_rd,
  input  logic [DW-1:0] st_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [IW-1:0] err_idx
);

  typedef enum logic [2:0] {S_IDLE, S_HALT, S_WIMG, S_BOOT, S_POLL, S_ERR} state_t;

  state_t        state;
  logic [IW-1:0] idx;
  logic [TW-1:0] cnt;
  logic          armed;
  logic          done_q;
  logic [IW-1:0] eidx;

  wire           last       = (idx == IW'(NPROC - 1));
  wire [DW-1:0]  ready_word = {8'(idx) + 8'd1, {(DW-8){1'b0}}};
  wire           hit        = armed && (st_data == ready_word);

  assign wr_en   = (state == S_HALT) || (state == S_BOOT);
  assign wr_addr = BASE + AW'(idx) * AW'(STRIDE);
  assign wr_data = (state == S_BOOT) ? BOOT_VAL : HALT_VAL;
  assign img_req = (state == S_WIMG);
  assign st_rd   = (state == S_POLL);
  assign cur_idx = idx;
  assign busy    = (state != S_IDLE) && (state != S_ERR);
  assign done    = done_q;
  assign err     = (state == S_ERR);
  assign err_idx = eidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      cnt    <= '0;
      armed  <= 1'b0;
      done_q <= 1'b0;
      eidx   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE, S_ERR: begin
          if (start) begin
            state <= S_HALT;
            idx   <= '0;
          end
        end
        S_HALT: begin
          if (last) begin
            idx   <= '0;
            state <= S_WIMG;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_WIMG: begin
          if (image_ready) state <= S_BOOT;
        end
        S_BOOT: begin
          state <= S_POLL;
          cnt   <= '0;
          armed <= 1'b0;
        end
        S_POLL: begin
          if (hit) begin
            if (last) begin
              done_q <= 1'b1;
              idx    <= '0;
              state  <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_WIMG;
            end
          end else if (cnt == tmo_limit) begin
            eidx  <= idx;
            state <= S_ERR;
          end else begin
            cnt   <= cnt + 1'b1;
            armed <= armed | (st_data != ready_word);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_halt_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == HALT_VAL && $past(wr_en && wr_data == HALT_VAL))
      |-> (wr_addr == $past(wr_addr) + AW'(STRIDE)));

  assert_boot_follows_img_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (img_req && image_ready) |=> (wr_en && wr_data == BOOT_VAL && $stable(cur_idx)));

  assert_single_boot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == BOOT_VAL) |=> !wr_en);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> (err && $stable(err_idx) && !wr_en));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !wr_en) |=> !(wr_en && wr_data == HALT_VAL && wr_addr == BASE));

endmodule

// File: tb/tb_boot_sequencer.sv
module tb_boot_sequencer;
  localparam logic [19:0] BASE = 20'h10800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tmo_limit = 16'd40;
  logic        wr_en, img_req, st_rd, busy, done, err;
  logic [19:0] wr_addr;
  logic [31:0] wr_data, st_data;
  logic        image_ready = 1'b0;
  logic [1:0]  cur_idx, err_idx;

  boot_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .img_req(img_req), .image_ready(image_ready), .cur_idx(cur_idx),
    .st_rd(st_rd), .st_data(st_data), .busy(busy), .done(done),
    .err(err), .err_idx(err_idx)
  );

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [31:0] stat [4];
  int dly [4];
  int tim [4];
  logic [19:0] laddr [16];
  logic [31:0] ldata [16];
  int nlog = 0, nboot = 0, img_cnt = 0, viol = 0, order_err = 0;

  assign st_data = stat[cur_idx];

  function automatic logic [31:0] rdy(int k);
    return {8'(k + 1), 24'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write log and processor status model
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (tim[k] > 0) begin
        tim[k] = tim[k] - 1;
        if (tim[k] == 2 || tim[k] == 1) stat[k] = 32'h0;
        if (tim[k] == 0) stat[k] = rdy(k);
      end
    end
    if (rst_n && wr_en) begin
      if (nlog < 16) begin
        laddr[nlog] = wr_addr;
        ldata[nlog] = wr_data;
      end
      nlog++;
      if (img_req) viol++;
      if (wr_data == 32'h30) begin
        int k;
        k = int'((wr_addr - BASE) >> 2) & 3;
        if (img_cnt != nboot + 1) order_err++;
        nboot++;
        if (dly[k] >= 0) tim[k] = dly[k] + 3;
      end
    end
  end

  // host image driver
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && img_req && !image_ready) begin
        repeat (2) @(negedge clk);
        image_ready = 1'b1;
        img_cnt++;
        @(negedge clk);
        image_ready = 1'b0;
      end
    end
  end

  // tmo, d3, d2, d1, d0 (FF = never answers), stale mask, expect error, expected index
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {8'd40, 8'd3,  8'd1,  8'd5,  8'd2,  4'b0000, 1'b0, 3'd0},
    {8'd40, 8'd0,  8'd0,  8'd0,  8'd0,  4'b0000, 1'b0, 3'd0},
    {8'd40, 8'd1,  8'd6,  8'd2,  8'd4,  4'b1010, 1'b0, 3'd0},
    {8'd20, 8'd2,  8'd2,  8'hFF, 8'd3,  4'b0000, 1'b1, 3'd1},
    {8'd20, 8'hFF, 8'd3,  8'd2,  8'd1,  4'b1000, 1'b1, 3'd3},
    {8'd20, 8'd1,  8'd1,  8'd1,  8'hFF, 4'b0000, 1'b1, 3'd0},
    {8'd5,  8'd3,  8'd3,  8'd3,  8'd3,  4'b0000, 1'b0, 3'd0},
    {8'd4,  8'd3,  8'd3,  8'd3,  8'd3,  4'b0000, 1'b1, 3'd0}
  };

  task automatic run_vec(input logic [47:0] v, input bit poke);
    int dn;
    int c;
    int nb;
    bit experr;
    int expidx;
    int snap;
    experr = v[3];
    expidx = int'(v[2:0]);
    @(negedge clk);
    tmo_limit = {8'h0, v[47:40]};
    for (int k = 0; k < 4; k++) begin
      dly[k] = (v[8 + 8*k +: 8] == 8'hFF) ? -1 : int'(v[8 + 8*k +: 8]);
      tim[k] = 0;
      stat[k] = v[4 + k] ? rdy(k) : 32'h0;
    end
    nlog = 0; nboot = 0; img_cnt = 0; viol = 0; order_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    c = 0;
    while (c < 3000 && dn == 0 && !err) begin
      @(negedge clk);
      c++;
      if (done) dn++;
      start = poke && busy && (c % 7 == 3);
    end
    start = 1'b0;
    snap = nlog;
    repeat (6) begin
      @(negedge clk);
      if (done) dn++;
    end
    for (int i = 0; i < 4; i++) begin
      chk(laddr[i] == BASE + 20'(4*i) && ldata[i] == 32'h10, "R2 halt write",
          {laddr[i], ldata[i]}, {BASE + 20'(4*i), 32'h10});
    end
    nb = experr ? expidx + 1 : 4;
    chk(nboot == nb, "R5 boot count", nboot, nb);
    chk(nlog == 4 + nb, "R10 total writes", nlog, 4 + nb);
    for (int j = 0; j < nb; j++) begin
      if (4 + j < 16)
        chk(laddr[4+j] == BASE + 20'(4*j) && ldata[4+j] == 32'h30, "R4 R5 boot write in order",
            {laddr[4+j], ldata[4+j]}, {BASE + 20'(4*j), 32'h30});
    end
    chk(viol == 0, "R3 write during image wait", viol, 0);
    chk(order_err == 0, "R4 boot before image handshake", order_err, 0);
    if (experr) begin
      chk(err == 1'b1, v[7:4] != 0 ? "R7 R8 stale word must time out" : "R8 error flag", err, 1);
      chk(err_idx == 2'(expidx), "R8 error index", err_idx, expidx);
      chk(nlog == snap, "R8 no writes after error", nlog, snap);
      chk(dn == 0, "R9 no done on error", dn, 0);
    end else begin
      chk(err == 1'b0, "R6 R8 no error", err, 0);
      chk(dn == 1, "R9 single done pulse", dn, 1);
      chk(busy == 1'b0, "R9 idle after done", busy, 0);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      stat[k] = 32'h0; dly[k] = 0; tim[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk({wr_en, img_req, busy, done, err} == 5'b0, "R1 outputs during reset",
        {wr_en, img_req, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({wr_en, img_req, busy, done, err} == 5'b0, "R1 outputs after reset",
        {wr_en, img_req, busy, done, err}, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R10: start pulses while busy must not restart the sequence
    run_vec(VEC[0], 1'b1);

    // R3: image wait holds off with no writes when host is slow is covered above;
    // R6: wrong ID in the status word must not be accepted
    @(negedge clk);
    tmo_limit = 16'd12;
    for (int k = 0; k < 4; k++) begin
      dly[k] = -1; tim[k] = 0; stat[k] = 32'h0;
    end
    nlog = 0; nboot = 0; img_cnt = 0; viol = 0; order_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!st_rd) @(negedge clk);
    stat[0] = rdy(1);
    repeat (20) @(negedge clk);
    chk(err == 1'b1 && err_idx == 2'd0, "R6 wrong ID rejected", {err, err_idx}, {1'b1, 2'd0});

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule